// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Source Mixer

This block assembles the timeslot-16 byte of an E1 transmit frame when channel-associated signaling is in use. The frames of a 16-frame signaling multiframe each carry two signaling nibbles. For every nibble the block either takes the value from a hardware signaling input or from one of sixteen internal signaling registers. A per-nibble select mask and a small set of global control bits make that choice.

A frame-sync pulse once per frame advances a 4-bit multiframe counter and loads the outgoing byte for the frame the counter was pointing at. Frame 0 carries the multiframe alignment word with the spare and remote-alarm bits. Frame k (1 to 15) carries voice channel k in its upper nibble and voice channel k+15 in its lower nibble. Software loads the registers through a plain address/data/write-strobe port. The hardware signaling arrives as one parallel nibble per voice channel, plus a separate byte for the frame-0 slot. A pass-through control hands the backplane's own timeslot-16 byte straight to the output.

Top module: `cas_sig_mixer`

## Requirements
- R1: Synchronous reset clears `ts16_out` to 0, `mf_frame` to 0, the multiframe counter to 0, the select mask to all zeros and all control bits to 0. The signaling registers keep their contents.
- R2: Each cycle with `fsync` high loads the byte for the counter's frame into `ts16_out`, copies that frame number into `mf_frame`, and advances the counter. The counter wraps from 15 to 0. Both outputs change on the clock edge that samples `fsync`.
- R3: In cycles without `fsync`, `ts16_out` and `mf_frame` hold their values.
- R4: Addresses 0 to 15 write signaling register k+1 (address k). Register 1 is the frame-0 byte. For frame k in 1..15, bits [7:4] of register k+1 are voice channel k and bits [3:0] are voice channel k+15.
- R5: With hardware enable (control bit 0) at 0, every nibble comes from the internal registers, whatever the per-channel mode and select bits hold.
- R6: With hardware enable at 1 and per-channel mode (control bit 1) at 0, every nibble comes from the hardware input. Voice channel n (1..30) is `hw_sig[4n-1:4n-4]`, and frame 0 is `ext_f0`.
- R7: With hardware enable and per-channel mode both at 1, select bit 2k picks the source of frame k's upper nibble and bit 2k+1 picks the source of its lower nibble. A 1 picks the register and a 0 picks the hardware input. Bits 0 and 1 cover the frame-0 slot.
- R8: With pass-through (control bit 2) at 1, the loaded byte is `bp_ts16`, whatever the other settings are.
- R9: Addresses 16 to 19 write select-mask bytes 0 to 3, so address 16+j bit b is select bit 8j+b. Address 20 writes the control bits. Writes to addresses 21 to 31 change nothing.
- R10: A write in the same cycle as `fsync` is not seen by that frame's byte. It takes effect from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| fsync | input | 1 | One-cycle pulse per E1 frame |
| hw_sig | input | 120 | Hardware signaling, one nibble per voice channel 1..30 |
| ext_f0 | input | 8 | Hardware byte for the frame-0 slot |
| bp_ts16 | input | 8 | Backplane timeslot-16 byte for pass-through |
| ts16_out | output | 8 | Registered timeslot-16 byte of the last frame |
| mf_frame | output | 4 | Multiframe position of `ts16_out` |

## Verification
Each frame byte and its frame tag are due on the very clock edge that samples `fsync`, with one register in the path. The bench raises `fsync` on a falling edge, lowers it on the next falling edge, and reads both outputs right then. Register writes land one edge after the strobe. Nothing is compared until the next pulse, except for the case where a write shares the pulse cycle and the older value is expected. Between pulses the bench lets idle cycles pass and confirms the outputs have not moved.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int SEL_BASE  = 16;
  localparam int CTRL_ADDR = 20;

  typedef struct packed {
    logic pass;    // bit 2
    logic per_ch;  // bit 1
    logic hw_en;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/cas_regfile.sv
module cas_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cas_mf_counter.sv
module cas_mf_counter #(
  parameter int NUM_FRAMES = 16,
  localparam int CW        = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(NUM_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R2: wrap from the last frame back to 0
  p_mf_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == LAST) |=> cnt == '0);
  // R2: step by one otherwise
  p_mf_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
  // R3: no movement without a pulse
  p_mf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));
endmodule

// File: rtl/cas_sig_select.sv
module cas_sig_select
  import cas_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int NIB_W      = 4,
  localparam int CW        = $clog2(NUM_FRAMES),
  localparam int HALF      = NUM_FRAMES - 1,
  localparam int BYTE_W    = 2 * NIB_W,
  localparam int SEL_W     = 2 * NUM_FRAMES
) (
  input  logic [CW-1:0]           frame,
  input  ctrl_t                   ctrl,
  input  logic [SEL_W-1:0]        sel,
  input  logic [BYTE_W-1:0]       reg_byte,
  input  logic [2*HALF*NIB_W-1:0] hw_sig,
  input  logic [BYTE_W-1:0]       ext_f0,
  input  logic [BYTE_W-1:0]       bp,
  output logic [BYTE_W-1:0]       byte_out
);
  logic [NIB_W-1:0] hw_hi, hw_lo;
  logic             use_reg_hi, use_reg_lo;

  always_comb begin
    hw_hi = ext_f0[BYTE_W-1:NIB_W];
    hw_lo = ext_f0[NIB_W-1:0];
    for (int c = 1; c <= HALF; c++) begin
      if (frame == CW'(c)) begin
        hw_hi = hw_sig[(c-1)*NIB_W +: NIB_W];
        hw_lo = hw_sig[(c+HALF-1)*NIB_W +: NIB_W];
      end
    end
  end

  always_comb begin
    use_reg_hi = 1'b1;
    use_reg_lo = 1'b1;
    if (ctrl.hw_en) begin
      if (ctrl.per_ch) begin
        use_reg_hi = sel[2*frame];
        use_reg_lo = sel[2*frame+1];
      end else begin
        use_reg_hi = 1'b0;
        use_reg_lo = 1'b0;
      end
    end
  end

  always_comb begin
    if (ctrl.pass) byte_out = bp;
    else byte_out = {use_reg_hi ? reg_byte[BYTE_W-1:NIB_W] : hw_hi,
                     use_reg_lo ? reg_byte[NIB_W-1:0]      : hw_lo};
  end
endmodule

// File: rtl/cas_sig_mixer.sv
module cas_sig_mixer
  import cas_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int NIB_W      = 4,
  parameter int ADDR_W     = 5
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [2*NIB_W-1:0]                    wr_data,
  input  logic                                  fsync,
  input  logic [2*(NUM_FRAMES-1)*NIB_W-1:0]     hw_sig,
  input  logic [2*NIB_W-1:0]                    ext_f0,
  input  logic [2*NIB_W-1:0]                    bp_ts16,
  output logic [2*NIB_W-1:0]                    ts16_out,
  output logic [$clog2(NUM_FRAMES)-1:0]         mf_frame
);
  localparam int CW       = $clog2(NUM_FRAMES);
  localparam int DATA_W   = 2 * NIB_W;
  localparam int SEL_W    = 2 * NUM_FRAMES;
  localparam int SEL_REGS = SEL_W / DATA_W;

  ctrl_t             ctrl_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rd_byte, mix_byte;
  logic              ts_we;

  assign ts_we = wr_en && (wr_addr < ADDR_W'(NUM_FRAMES));

  cas_regfile #(.DEPTH(NUM_FRAMES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .we(ts_we), .waddr(wr_addr[CW-1:0]), .wdata(wr_data),
    .raddr(cnt), .rdata(rd_byte));

  cas_mf_counter #(.NUM_FRAMES(NUM_FRAMES)) u_cnt (
    .clk(clk), .rst(rst), .adv(fsync), .cnt(cnt));

  cas_sig_select #(.NUM_FRAMES(NUM_FRAMES), .NIB_W(NIB_W)) u_sel (
    .frame(cnt), .ctrl(ctrl_q), .sel(sel_q), .reg_byte(rd_byte),
    .hw_sig(hw_sig), .ext_f0(ext_f0), .bp(bp_ts16), .byte_out(mix_byte));

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= ctrl_t'(wr_data[2:0]);
      for (int j = 0; j < SEL_REGS; j++) begin
        if (wr_addr == ADDR_W'(SEL_BASE + j)) sel_q[j*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

  // once-per-frame output register
  always_ff @(posedge clk) begin
    if (rst) begin
      ts16_out <= '0;
      mf_frame <= '0;
    end else if (fsync) begin
      ts16_out <= mix_byte;
      mf_frame <= cnt;
    end
  end

  // R1: outputs cleared by reset
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (ts16_out == '0 && mf_frame == '0));
  // R2: output tag follows the counter
  p_tag_r2: assert property (@(posedge clk) disable iff (rst)
    fsync |=> mf_frame == $past(cnt));
  // R3: byte held between pulses
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> ($stable(ts16_out) && $stable(mf_frame)));
  // R5: hardware disabled means register content
  p_internal_r5: assert property (@(posedge clk) disable iff (rst)
    (fsync && !ctrl_q.pass && !ctrl_q.hw_en) |=> ts16_out == $past(rd_byte));
  // R8: pass-through byte
  p_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (fsync && ctrl_q.pass) |=> ts16_out == $past(bp_ts16));
endmodule

// File: tb/cas_sig_mixer_tb.sv
module cas_sig_mixer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 16;

  logic         clk = 0, rst = 1, wr_en = 0, fsync = 0;
  logic [4:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0, ext_f0 = 8'h0B, bp_ts16 = 8'hC3;
  logic [119:0] hw_sig;
  logic [7:0]   ts16_out;
  logic [3:0]   mf_frame;

  int checks = 0, errors = 0, fr = 0;
  bit done = 0;
  logic [7:0] ts_m [NF];

  // {ctrl[2:0], sel[31:0]}
  localparam logic [34:0] VEC [8] = '{
    {3'b000, 32'h0000_0000},
    {3'b000, 32'hFFFF_FFFF},
    {3'b010, 32'hFFFF_FFFF},
    {3'b001, 32'hFFFF_FFFF},
    {3'b011, 32'h0000_0003},
    {3'b011, 32'hA5C3_0F13},
    {3'b011, 32'h0000_0C03},
    {3'b111, 32'h1234_5678}
  };

  cas_sig_mixer u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsync(fsync), .hw_sig(hw_sig), .ext_f0(ext_f0),
    .bp_ts16(bp_ts16), .ts16_out(ts16_out), .mf_frame(mf_frame));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] hwn(int n);
    return 4'((n * 7 + 3) % 16);
  endfunction

  function automatic logic [7:0] model(int f, logic [2:0] c, logic [31:0] s);
    logic [7:0] ib, hb;
    ib = ts_m[f];
    hb = (f == 0) ? ext_f0 : {hwn(f), hwn(f + 15)};
    if (c[2]) return bp_ts16;
    if (!c[0]) return ib;
    if (!c[1]) return hb;
    return {s[2*f] ? ib[7:4] : hb[7:4], s[2*f+1] ? ib[3:0] : hb[3:0]};
  endfunction

  function automatic string tag(logic [2:0] c);
    if (c[2]) return "R8";
    if (!c[0]) return "R5";
    if (!c[1]) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); fsync = 1;
    @(negedge clk); fsync = 0;
  endtask

  task automatic frame_check(string req, logic [2:0] c, logic [31:0] s);
    pulse();
    check(req, ts16_out, model(fr, c, s));
    check("R2", {4'h0, mf_frame}, 8'(fr));
    fr = (fr + 1) % NF;
  endtask

  initial begin
    for (int n = 1; n <= 30; n++) hw_sig[(n-1)*4 +: 4] = hwn(n);
    for (int i = 0; i < NF; i++) ts_m[i] = 8'h5A ^ 8'(i * 8'h13);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", ts16_out, 8'h00);
    check("R1", {4'h0, mf_frame}, 8'h00);
    // R4: load signaling registers
    for (int i = 0; i < NF; i++) wr(5'(i), ts_m[i]);
    check("R3", ts16_out, 8'h00);
    // R1/R4: controls cleared -> internal source, frame 0 is register 1
    frame_check("R1", 3'b000, 32'h0);
    for (int k = 1; k < NF; k++) begin
      frame_check("R4", 3'b000, 32'h0);
      repeat (2) @(negedge clk);
      check("R3", ts16_out, model((fr + NF - 1) % NF, 3'b000, 32'h0));
    end
    // table of modes (R5..R9)
    for (int v = 0; v < 8; v++) begin
      logic [2:0] c;
      logic [31:0] s;
      c = VEC[v][34:32];
      s = VEC[v][31:0];
      for (int j = 0; j < 4; j++) wr(5'(16 + j), s[j*8 +: 8]);
      wr(5'd20, {5'b0, c});
      for (int k = 0; k < NF; k++) frame_check(tag(c), c, s);
    end
    // R9: writes to unused addresses change nothing
    for (int j = 0; j < 4; j++) wr(5'(16 + j), 8'h00);
    wr(5'd20, 8'h00);
    for (int a = 21; a < 32; a++) wr(5'(a), 8'hFF);
    for (int k = 0; k < NF; k++) frame_check("R9", 3'b000, 32'h0);
    // R10: write coinciding with fsync is not seen this frame
    @(negedge clk);
    fsync = 1; wr_en = 1; wr_addr = 5'(fr); wr_data = 8'hE7;
    @(negedge clk);
    fsync = 0; wr_en = 0;
    check("R10", ts16_out, ts_m[fr]);
    ts_m[fr] = 8'hE7;
    fr = (fr + 1) % NF;
    for (int k = 0; k < NF; k++) frame_check("R10", 3'b000, 32'h0);
    // R1/R2: reset mid-multiframe returns to frame 0
    frame_check("R2", 3'b000, 32'h0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1", ts16_out, 8'h00);
    check("R1", {4'h0, mf_frame}, 8'h00);
    fr = 0;
    frame_check("R1", 3'b000, 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule